// File: doc/BRIEF.md
# UART Receive Character Timeout Detector

This block sits beside a UART receive FIFO and raises a character timeout interrupt when characters have waited in the FIFO, unread, for four full character times. The length of one character is taken live from the configured frame length in bits, counting start, data, parity and stop bits. The timer advances on a baud tick that runs at sixteen ticks per bit period, so the terminal count is 4 x 16 x frame bits ticks. For example, a 12-bit frame gives 768 ticks, about 857 us at 56000 baud.

The timer counts only while the FIFO holds at least one character. Its restart rules depend on whether a timeout is already pending. With no timeout pending, either a newly received character or a CPU read of the FIFO restarts it. Once a timeout has fired, only a CPU read of one character clears it and restarts the timer. The detector is armed only when both the FIFO and receive interrupts are enabled. In FIFO polled mode it stays silent.

No data passes through the block. All pins are plain control and status levels or single-cycle strobes, so there is no valid/ready handshake and no back-pressure. The interrupt code output is meant to be merged at the second priority level with the trigger-level and data-available sources.

Top module: `rx_char_timeout`

## Requirements
- R1: With the block armed and the FIFO non-empty, the interrupt request rises at the clock edge that takes the 4 x 16 x frame_bits-th baud tick since the last restart, and not before.
- R2: Only clock cycles with baud_tick high advance the timer; cycles without a tick leave the progress unchanged.
- R3: While no timeout is pending, a receive strobe or a FIFO read strobe restarts the timer from zero. This holds even when a baud tick arrives in the same cycle.
- R4: While a timeout is pending, a receive strobe has no effect: the request stays high.
- R5: While a timeout is pending, a FIFO read strobe clears the request at that edge and restarts the timer from zero.
- R6: The timer does not advance while the FIFO is empty. Any cycle with the FIFO empty returns it to zero.
- R7: When either fifo_en or rx_irq_en is low, no timeout is raised and any pending timeout is cleared at the next edge.
- R8: irq_id reads 4'b1100 while the timeout is pending and 4'b0001 (nothing pending) otherwise.
- R9: After reset the request is low and irq_id reads 4'b0001.
- R10: A frame length of zero never raises a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| frame_bits | input | FRAME_W (4) | Bits per character frame, start to last stop bit |
| fifo_en | input | 1 | FIFOs enabled |
| rx_irq_en | input | 1 | Receive interrupts enabled |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_char_stb | input | 1 | A character was written into the FIFO this cycle |
| fifo_rd_stb | input | 1 | The CPU popped one character this cycle |
| timeout_irq | output | 1 | Character timeout pending |
| irq_id | output | 4 | Interrupt identification code for this source |

## Verification
Every result is registered once. A strobe, tick or mode change driven before a rising edge shows on timeout_irq and irq_id just after that same edge, with no further latency. The bench drives inputs and samples outputs on the falling edge, one edge after each stimulus. It counts baud ticks itself from the last restart, and it checks the request low after tick limit-1 and high after tick limit. A sweep covers every frame length from 1 to 15 at two tick spacings. Directed cases then place restarts, empty cycles and mode changes at chosen tick counts.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int TIMEOUT_CHARS = 4;
  localparam logic [3:0] ID_NONE    = 4'b0001;
  localparam logic [3:0] ID_TIMEOUT = 4'b1100;
endpackage

// File: rtl/rxto_limit.sv
module rxto_limit #(
  parameter int FRAME_W = 4,
  parameter int SCALE   = 64,
  parameter int CNT_W   = 10
) (
  input  logic [FRAME_W-1:0] frame_bits,
  output logic [CNT_W-1:0]   limit,
  output logic               limit_valid
);
  localparam logic [CNT_W-1:0] SCALE_C = CNT_W'(SCALE);

  always_comb begin
    limit       = CNT_W'(frame_bits) * SCALE_C;
    limit_valid = (frame_bits != '0);
  end
endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             baud_tick,
  input  logic             restart,
  input  logic             frozen,
  input  logic [CNT_W-1:0] limit,
  input  logic             limit_valid,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic advance;

  always_comb begin
    advance = run && baud_tick && !restart && !frozen && limit_valid;
    hit     = advance && (cnt == limit - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || restart)   cnt <= '0;
    else if (advance && !hit)   cnt <= cnt + CNT_W'(1);
    else if (hit)               cnt <= '0;
  end

  assert_zero_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  assert_no_tick_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !baud_tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic rx_char_stb,
  input  logic fifo_rd_stb,
  input  logic hit,
  output logic restart,
  output logic pending
);
  always_comb restart = fifo_rd_stb || (rx_char_stb && !pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (!armed)   pending <= 1'b0;
    else if (pending)  pending <= !fifo_rd_stb;
    else               pending <= hit;
  end

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && fifo_rd_stb) |=> !pending);
  assert_rx_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && armed && rx_char_stb && !fifo_rd_stb) |=> pending);
  assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !pending);
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
  import rxto_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic               fifo_en,
  input  logic               rx_irq_en,
  input  logic               fifo_nonempty,
  input  logic               rx_char_stb,
  input  logic               fifo_rd_stb,
  output logic               timeout_irq,
  output logic [3:0]         irq_id
);
  localparam int SCALE = TICKS_PER_BIT * TIMEOUT_CHARS;
  localparam int CNT_W = FRAME_W + $clog2(SCALE);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             limit_valid;
  logic             armed;
  logic             run;
  logic             restart;
  logic             hit;
  logic             pending;

  always_comb begin
    armed = fifo_en && rx_irq_en;
    run   = armed && fifo_nonempty;
  end

  rxto_limit #(.FRAME_W(FRAME_W), .SCALE(SCALE), .CNT_W(CNT_W)) u_limit (
    .frame_bits  (frame_bits),
    .limit       (limit),
    .limit_valid (limit_valid)
  );

  rxto_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .baud_tick   (baud_tick),
    .restart     (restart),
    .frozen      (pending),
    .limit       (limit),
    .limit_valid (limit_valid),
    .cnt         (cnt),
    .hit         (hit)
  );

  rxto_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed       (armed),
    .rx_char_stb (rx_char_stb),
    .fifo_rd_stb (fifo_rd_stb),
    .hit         (hit),
    .restart     (restart),
    .pending     (pending)
  );

  always_comb begin
    timeout_irq = pending;
    irq_id      = pending ? ID_TIMEOUT : ID_NONE;
  end

  assert_fire_at_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_irq) |-> ($past(cnt) == limit - CNT_W'(1)));
  assert_fire_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_irq) |-> $past(baud_tick));
  assert_zero_frame_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bits == '0) && $past(frame_bits == '0) && !$past(timeout_irq) |-> !timeout_irq);
endmodule

// File: tb/tb_rx_char_timeout.sv
module tb_rx_char_timeout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [3:0] frame_bits = 4'd2;
  logic       fifo_en = 1'b1;
  logic       rx_irq_en = 1'b1;
  logic       fifo_nonempty = 1'b1;
  logic       rx_char_stb = 1'b0;
  logic       fifo_rd_stb = 1'b0;
  logic       timeout_irq;
  logic [3:0] irq_id;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_char_timeout #(.FRAME_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .frame_bits(frame_bits),
    .fifo_en(fifo_en), .rx_irq_en(rx_irq_en), .fifo_nonempty(fifo_nonempty),
    .rx_char_stb(rx_char_stb), .fifo_rd_stb(fifo_rd_stb),
    .timeout_irq(timeout_irq), .irq_id(irq_id)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit t, input bit rx, input bit rd);
    baud_tick = t; rx_char_stb = rx; fifo_rd_stb = rd;
    @(posedge clk);
    @(negedge clk);
    baud_tick = 1'b0; rx_char_stb = 1'b0; fifo_rd_stb = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic clear_read();
    cyc(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset irq", timeout_irq, 0);
    chk("R9 reset id", irq_id, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: every frame length, tick every cycle and every third cycle
    for (int fb = 1; fb <= 15; fb++) begin
      for (int dv = 1; dv <= 3; dv += 2) begin
        int lim;
        lim = 64 * fb;
        frame_bits = 4'(fb);
        clear_read();
        for (int k = 1; k <= lim; k++) begin
          for (int g = 1; g < dv; g++) cyc(1'b0, 1'b0, 1'b0);
          if (k == lim) chk("R2 idle cycles hold progress", timeout_irq, 0);
          cyc(1'b1, 1'b0, 1'b0);
          if (k == lim - 1) chk("R1 quiet before limit", timeout_irq, 0);
        end
        chk("R1 fires at limit", timeout_irq, 1);
        chk("R8 id pending", irq_id, 12);
        clear_read();
        chk("R5 read clears", timeout_irq, 0);
        chk("R8 id idle", irq_id, 1);
      end
    end

    // R3: receive strobe restarts, even together with a tick
    frame_bits = 4'd2;
    clear_read();
    ticks(100);
    cyc(1'b1, 1'b1, 1'b0);
    ticks(127);
    chk("R3 rx restart not yet", timeout_irq, 0);
    ticks(1);
    chk("R3 rx restart fires", timeout_irq, 1);
    clear_read();
    ticks(120);
    cyc(1'b1, 1'b0, 1'b1);
    ticks(127);
    chk("R3 read restart not yet", timeout_irq, 0);
    ticks(1);
    chk("R3 read restart fires", timeout_irq, 1);

    // R4: receive strobe ignored while pending
    cyc(1'b1, 1'b1, 1'b0);
    chk("R4 rx ignored", timeout_irq, 1);
    ticks(50);
    chk("R4 stays pending", timeout_irq, 1);
    // R5: read clears and restarts
    cyc(1'b1, 1'b0, 1'b1);
    chk("R5 cleared", timeout_irq, 0);
    ticks(127);
    chk("R5 restart not yet", timeout_irq, 0);
    ticks(1);
    chk("R5 refires", timeout_irq, 1);
    clear_read();

    // R6: empty FIFO holds timer at zero
    fifo_nonempty = 1'b0;
    ticks(300);
    chk("R6 empty silent", timeout_irq, 0);
    fifo_nonempty = 1'b1;
    ticks(100);
    fifo_nonempty = 1'b0;
    ticks(1);
    fifo_nonempty = 1'b1;
    ticks(127);
    chk("R6 empty resets", timeout_irq, 0);
    ticks(1);
    chk("R6 count after empty", timeout_irq, 1);
    clear_read();

    // R7: disabled modes
    fifo_en = 1'b0;
    ticks(300);
    chk("R7 fifo off silent", timeout_irq, 0);
    fifo_en = 1'b1; rx_irq_en = 1'b0;
    ticks(300);
    chk("R7 polled silent", timeout_irq, 0);
    rx_irq_en = 1'b1;
    clear_read();
    ticks(128);
    chk("R7 armed fires", timeout_irq, 1);
    rx_irq_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R7 disarm clears", timeout_irq, 0);
    rx_irq_en = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R7 stays cleared", timeout_irq, 0);
    chk("R8 id after clear", irq_id, 1);

    // R10: zero frame length never fires
    frame_bits = 4'd0;
    clear_read();
    ticks(2000);
    chk("R10 zero frame silent", timeout_irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule